// File: doc/BRIEF.md
# Load-Use Stall Unit with Pipeline Front Model

This block spots the one read-after-write case in a five-stage in-order pipeline that forwarding cannot cover. That case is an instruction in decode that needs a register which a load, currently in execute, will only get from data memory one stage later. When it sees this, the block inserts a single stall cycle while the consumer is still in decode. The PC and the fetch/decode register are frozen. The control and destination fields written into the decode/execute register are cleared, so the slot that moves on is a harmless bubble.

The hazard comparator sits inside a small register-accurate model of the pipeline front. The model has a PC, a fetch/decode register, a decode/execute register and the two later stage registers. The fetch side receives the fields of the instruction addressed by `pc_o`. The block reports its stall controls and the contents of the execute and writeback slots, so the whole timeline can be seen at the ports.

Top module: `ldu_stall_pipe`

## Requirements
- R1: When the execute slot holds a load (memory-read flag 1) whose destination is nonzero and equals a decode source register whose use flag is 1, `bubble_o` is 1 in that same cycle.
- R2: A load whose destination is register 0 never raises a stall.
- R3: A source field whose use flag is 0 never causes a stall, even when its number equals the load destination.
- R4: An execute-slot instruction with memory-read 0 never causes a stall.
- R5: In a stall cycle `pc_we_o` is 0 and `pc_o` keeps its value at the next edge. The same instruction is therefore fetched again.
- R6: In a stall cycle `ifid_we_o` is 0 and the decoding instruction stays in decode for one more cycle.
- R7: After a stall cycle the execute slot carries destination 0 and register-write, memory-read and memory-write all 0.
- R8: A stalled consumer reaches execute one cycle after the bubble. In that cycle the load sits in the writeback slot with memory-read 1 and its destination visible, ready for forwarding from that register.
- R9: Each load-use pair costs exactly one stall cycle. Two back-to-back loads followed by a consumer of both stall once, and a chain of load, dependent load, consumer stalls twice.
- R10: While `rst_ni` is low, `pc_o` is 0, all stage registers hold zero, `bubble_o` is 0 and both write enables are 1.
- R11: In every cycle without a stall, `pc_o` advances by PC_STEP (default 4) at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_rd_i | input | REG_AW | Destination register of the fetched instruction |
| if_rs1_i | input | REG_AW | First source register of the fetched instruction |
| if_rs2_i | input | REG_AW | Second source register of the fetched instruction |
| if_use_rs1_i | input | 1 | First source is actually read |
| if_use_rs2_i | input | 1 | Second source is actually read |
| if_regwr_i | input | 1 | Register-write control of the fetched instruction |
| if_memrd_i | input | 1 | Memory-read (load) control of the fetched instruction |
| if_memwr_i | input | 1 | Memory-write control of the fetched instruction |
| pc_o | output | PC_W | Current fetch address |
| pc_we_o | output | 1 | PC write enable, low during a stall |
| ifid_we_o | output | 1 | Fetch/decode register write enable, low during a stall |
| bubble_o | output | 1 | Clears the decode/execute register at the next edge |
| ex_rd_o | output | REG_AW | Destination in the execute slot |
| ex_regwr_o | output | 1 | Register-write in the execute slot |
| ex_memrd_o | output | 1 | Memory-read in the execute slot |
| ex_memwr_o | output | 1 | Memory-write in the execute slot |
| wb_rd_o | output | REG_AW | Destination in the writeback slot |
| wb_regwr_o | output | 1 | Register-write in the writeback slot |
| wb_memrd_o | output | 1 | Memory-read in the writeback slot |
| wb_memwr_o | output | 1 | Memory-write in the writeback slot |

## Verification
Some properties are checked on every cycle. A bubble always leaves a control-free execute slot. A bubble never repeats in the next cycle. A register-0 load never stalls. The PC either holds or steps by PC_STEP, as the enable says.

Other behaviour can only be shown by the bench scenarios. These cover the exact decode cycle in which the stall appears and the refetch of the held instruction. They also show the consumer arriving in execute alongside the load in writeback, and the total stall count for the back-to-back and chained load sequences. A sweep over every destination, source and use-flag combination of a four-register configuration covers the comparator's match and no-match cases.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef struct packed {
    logic reg_wr;
    logic mem_rd;
    logic mem_wr;
  } ctrl_t;
  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic              ex_mem_rd_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  output logic              stall_o
);
  logic [1:0] hit;
  logic [REG_AW-1:0] src [2];
  logic [1:0] use_src;

  assign src[0]  = id_rs1_i;
  assign src[1]  = id_rs2_i;
  assign use_src = {id_use_rs2_i, id_use_rs1_i};

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    assign hit[g] = use_src[g] && (src[g] == ex_rd_i);
  end

  // register 0 is never a real producer
  assign stall_o = ex_mem_rd_i && (ex_rd_i != '0) && (|hit);
endmodule

// File: rtl/ldu_pc_gen.sv
module ldu_pc_gen #(
  parameter int unsigned PC_W    = 8,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_o <= '0;
    else if (we_i) pc_o <= pc_o + STEP;
  end
endmodule

// File: rtl/ldu_stage_reg.sv
module ldu_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (we_i)  q_o <= d_i;
  end
endmodule

// File: rtl/ldu_stall_pipe.sv
module ldu_stall_pipe
  import ldu_pkg::*;
#(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned PC_W    = 8,
  parameter int unsigned PC_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] if_rd_i,
  input  logic [REG_AW-1:0] if_rs1_i,
  input  logic [REG_AW-1:0] if_rs2_i,
  input  logic              if_use_rs1_i,
  input  logic              if_use_rs2_i,
  input  logic              if_regwr_i,
  input  logic              if_memrd_i,
  input  logic              if_memwr_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              bubble_o,
  output logic [REG_AW-1:0] ex_rd_o,
  output logic              ex_regwr_o,
  output logic              ex_memrd_o,
  output logic              ex_memwr_o,
  output logic [REG_AW-1:0] wb_rd_o,
  output logic              wb_regwr_o,
  output logic              wb_memrd_o,
  output logic              wb_memwr_o
);
  localparam int unsigned ID_W   = 3 * REG_AW + 2 + CTRL_W;
  localparam int unsigned EX_W   = REG_AW + CTRL_W;
  localparam int unsigned N_LATE = 2; // execute->memory, memory->writeback

  logic [ID_W-1:0] if_word, id_word;
  logic [REG_AW-1:0] id_rd, id_rs1, id_rs2;
  logic id_use1, id_use2;
  ctrl_t id_ctrl, ex_ctrl, wb_ctrl;
  logic [EX_W-1:0] late_q [N_LATE+1];
  logic stall;

  assign if_word = {if_rd_i, if_rs1_i, if_rs2_i, if_use_rs1_i, if_use_rs2_i,
                    if_regwr_i, if_memrd_i, if_memwr_i};
  assign {id_rd, id_rs1, id_rs2, id_use1, id_use2, id_ctrl} = id_word;

  ldu_hazard_detect #(.REG_AW(REG_AW)) u_hzd (
    .id_rs1_i     (id_rs1),
    .id_rs2_i     (id_rs2),
    .id_use_rs1_i (id_use1),
    .id_use_rs2_i (id_use2),
    .ex_mem_rd_i  (ex_ctrl.mem_rd),
    .ex_rd_i      (ex_rd_o),
    .stall_o      (stall)
  );

  assign pc_we_o   = !stall;
  assign ifid_we_o = !stall;
  assign bubble_o  = stall;

  ldu_pc_gen #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pc_we_o),
    .pc_o   (pc_o)
  );

  ldu_stage_reg #(.W(ID_W)) u_ifid (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ifid_we_o),
    .clr_i  (1'b0),
    .d_i    (if_word),
    .q_o    (id_word)
  );

  ldu_stage_reg #(.W(EX_W)) u_idex (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (1'b1),
    .clr_i  (bubble_o),
    .d_i    ({id_rd, id_ctrl}),
    .q_o    (late_q[0])
  );

  for (genvar s = 0; s < N_LATE; s++) begin : g_late
    ldu_stage_reg #(.W(EX_W)) u_stg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (1'b1),
      .clr_i  (1'b0),
      .d_i    (late_q[s]),
      .q_o    (late_q[s+1])
    );
  end

  assign {ex_rd_o, ex_ctrl} = late_q[0];
  assign {wb_rd_o, wb_ctrl} = late_q[N_LATE];
  assign ex_regwr_o = ex_ctrl.reg_wr;
  assign ex_memrd_o = ex_ctrl.mem_rd;
  assign ex_memwr_o = ex_ctrl.mem_wr;
  assign wb_regwr_o = wb_ctrl.reg_wr;
  assign wb_memrd_o = wb_ctrl.mem_rd;
  assign wb_memwr_o = wb_ctrl.mem_wr;

  a_r7_bubble_clears_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |=> (!ex_regwr_o && !ex_memrd_o && !ex_memwr_o && ex_rd_o == '0));

  a_r9_single_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |=> !bubble_o);

  a_r2_no_stall_rd0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_o == '0) |-> !bubble_o);

  a_r5_pc_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_o |=> $stable(pc_o));

  a_r11_pc_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> (pc_o == $past(pc_o) + PC_W'(PC_STEP)));

  a_r4_no_stall_non_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_memrd_o |-> !bubble_o);
endmodule

// File: tb/ldu_stall_pipe_tb.sv
`timescale 1ns/1ps
module ldu_stall_pipe_tb;
  localparam int unsigned RAW = 2;
  localparam int unsigned PCW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [RAW-1:0] p_rd [16], p_rs1 [16], p_rs2 [16];
  logic p_u1 [16], p_u2 [16], p_wr [16], p_mr [16], p_mw [16];

  logic [PCW-1:0] pc;
  logic pc_we, ifid_we, bubble;
  logic [RAW-1:0] ex_rd, wb_rd;
  logic ex_regwr, ex_memrd, ex_memwr, wb_regwr, wb_memrd, wb_memwr;
  logic [3:0] idx;
  assign idx = pc[5:2];

  ldu_stall_pipe #(.REG_AW(RAW), .PC_W(PCW), .PC_STEP(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .if_rd_i(p_rd[idx]), .if_rs1_i(p_rs1[idx]), .if_rs2_i(p_rs2[idx]),
    .if_use_rs1_i(p_u1[idx]), .if_use_rs2_i(p_u2[idx]),
    .if_regwr_i(p_wr[idx]), .if_memrd_i(p_mr[idx]), .if_memwr_i(p_mw[idx]),
    .pc_o(pc), .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble),
    .ex_rd_o(ex_rd), .ex_regwr_o(ex_regwr), .ex_memrd_o(ex_memrd), .ex_memwr_o(ex_memwr),
    .wb_rd_o(wb_rd), .wb_regwr_o(wb_regwr), .wb_memrd_o(wb_memrd), .wb_memwr_o(wb_memwr)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) begin
      p_rd[i] = '0; p_rs1[i] = '0; p_rs2[i] = '0;
      p_u1[i] = 0; p_u2[i] = 0; p_wr[i] = 0; p_mr[i] = 0; p_mw[i] = 0;
    end
  endtask

  task automatic put(input int i, input int rd, input int r1, input int r2,
                     input bit u1, input bit u2, input bit wr, input bit mr);
    p_rd[i] = RAW'(rd); p_rs1[i] = RAW'(r1); p_rs2[i] = RAW'(r2);
    p_u1[i] = u1; p_u2[i] = u2; p_wr[i] = wr; p_mr[i] = mr; p_mw[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_count(input int edges, output int stalls);
    stalls = 0;
    for (int k = 0; k < edges; k++) begin
      step();
      if (bubble) stalls++;
    end
  endtask

  initial begin
    #500us;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st;
    clear_prog();
    // R10: reset state
    @(negedge clk); @(negedge clk);
    check(pc == 0, "R10 pc", int'(pc), 0);
    check(bubble == 0 && pc_we == 1 && ifid_we == 1, "R10 ctl", int'(bubble), 0);
    check(ex_rd == 0 && !ex_regwr && !ex_memrd && !wb_memrd && wb_rd == 0, "R10 regs", int'(ex_rd), 0);

    // sweep: I0 producer (rd=a, load if m), I1 consumer (rs1=b, rs2=c, flags u)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++)
            for (int u = 0; u < 4; u++) begin
              bit exp;
              string tag;
              exp = (m == 1) && (a != 0) && ((u[0] && b == a) || (u[1] && c == a));
              if (m == 0) tag = "R4";
              else if (a == 0) tag = "R2";
              else if (!exp && (b == a || c == a)) tag = "R3";
              else tag = "R1";
              clear_prog();
              put(0, a, 0, 0, 0, 0, 1, m[0]);
              put(1, 3, b, c, u[0], u[1], 1, 0);
              do_reset();
              step(); step();
              check(bubble == exp, tag, int'(bubble), int'(exp));
              check(pc_we == !exp, "R5 we", int'(pc_we), int'(!exp));
              check(ifid_we == !exp, "R6 we", int'(ifid_we), int'(!exp));
              step();
              check(pc == (exp ? 8 : 12), "R5 pc", int'(pc), exp ? 8 : 12);
              check(ex_rd == (exp ? 0 : 3) && ex_regwr == !exp && !ex_memrd,
                    "R7", int'(ex_rd), exp ? 0 : 3);
              check(bubble == 0, "R9 once", int'(bubble), 0);
              if (exp) begin
                step();
                check(ex_rd == 3 && ex_regwr, "R6 R8 consumer", int'(ex_rd), 3);
                check(wb_memrd && wb_rd == RAW'(a), "R8 wb", int'(wb_rd), a);
              end
            end

    // R9: two loads then a consumer of both -> one stall
    clear_prog();
    put(0, 1, 0, 0, 0, 0, 1, 1);
    put(1, 2, 3, 0, 1, 0, 1, 1);
    put(2, 3, 1, 2, 1, 1, 1, 0);
    do_reset();
    run_count(12, st);
    check(st == 1, "R9 back2back", st, 1);
    check(pc == 44, "R9 R11 pc", int'(pc), 44);

    // R9: chained load -> dependent load -> consumer -> two stalls
    clear_prog();
    put(0, 1, 0, 0, 0, 0, 1, 1);
    put(1, 2, 1, 0, 1, 0, 1, 1);
    put(2, 3, 0, 2, 0, 1, 1, 0);
    do_reset();
    run_count(12, st);
    check(st == 2, "R9 chain", st, 2);
    check(pc == 40, "R9 R11 pc", int'(pc), 40);

    // R11: no hazards, plain streaming
    clear_prog();
    do_reset();
    run_count(10, st);
    check(st == 0 && pc == 40, "R11 stream", int'(pc), 40);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule